// File: doc/BRIEF.md
# Predictive Ring Snoop Controller

Each node on a unidirectional snooping ring has one of these controllers. For every snoop request that arrives from the upstream neighbour, the controller picks one of three actions. It can snoop the local cache and then forward the request, carrying a flag that says whether this node will supply the line. It can forward at once and snoop in parallel. Or it can only forward, leaving the local cache untouched. The lazy and eager policies are fixed baselines. The adaptive policies decide per request, using a supplier predictor that must never miss a line the node actually holds.

The predictor has two parts. The first is a counting Bloom filter: each cached supplier line raises two counters, picked by two hashes of its address, and an eviction lowers them again. The second is a small exclude table of addresses that recently produced a false positive. A hit in the exclude table overrides a filter hit and turns the prediction into "not a supplier". A cache fill removes any matching exclude entry, which keeps a real supplier from being predicted away. The prediction, and therefore the decision, comes out a fixed three cycles after a request is accepted.

Top module: `ring_snoop_ctl`

## Requirements
- R1: A request accepted at clock edge k (req_valid and ring_in_ready both high) produces its decision in the cycle that follows edge k+2. In that cycle dec_valid is high and dec_action carries the action: 1 for snoop-then-forward, 2 for forward-then-snoop, 3 for forward-only.
- R2: Snoop-then-forward raises snp_valid in the decision cycle. In the next cycle it raises ring_out_valid with the same address, and ring_out_supply equals the snp_hit value from the decision cycle. When mode is 0 (lazy), every decision is snoop-then-forward.
- R3: Forward-then-snoop raises snp_valid and ring_out_valid together in the decision cycle, with ring_out_supply low. When mode is 1 (eager), every decision is forward-then-snoop.
- R4: In the adaptive modes the prediction is "supplier" when two counters are nonzero and the exclude table has no entry for the address. The first counter is indexed by h0 = a[4:0]^a[9:5]. The second is indexed by h1 = {a[3:0],a[4]}^a[15:11]. A supplier prediction gives snoop-then-forward in mode 2 (conservative) and forward-then-snoop in mode 3 (aggressive). Any other prediction gives forward-only: ring_out_valid is high and snp_valid stays low.
- R5: A fill increments both counters of its address and invalidates any exclude entry for that address. A filled line is therefore never given forward-only, even if it was excluded before.
- R6: An exclude entry is written when a snoop issued on a supplier prediction returns snp_hit low. Later requests for that address are then forward-only. The four entries are replaced in round-robin order, so a fifth distinct insertion replaces the first one.
- R7: An evict decrements both counters of its address. When no other line shares a counter, the address returns to forward-only.
- R8: A forward-then-snoop or forward-only decision may land in the cycle where a snoop-then-forward forward is pending. In that case ring_in_ready is low for that one cycle and the pipeline holds. The held decision comes out in the following cycle.
- R9: After reset every output valid is low, ring_in_ready is high and all counters are zero, so adaptive modes give forward-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 lazy, 1 eager, 2 adaptive conservative, 3 adaptive aggressive |
| req_valid | input | 1 | Incoming ring request present |
| req_addr | input | ADDR_W | Line address of incoming request |
| ring_in_ready | output | 1 | Request is taken at this edge |
| ring_out_valid | output | 1 | Request forwarded downstream |
| ring_out_addr | output | ADDR_W | Forwarded line address |
| ring_out_supply | output | 1 | This node will supply the line |
| snp_valid | output | 1 | Local cache snoop issued |
| snp_addr | output | ADDR_W | Snoop address |
| snp_hit | input | 1 | Cache can supply the snooped line (same cycle) |
| fill_valid | input | 1 | Cache gained a supplier line |
| fill_addr | input | ADDR_W | Filled line address |
| evict_valid | input | 1 | Cache lost a supplier line |
| evict_addr | input | ADDR_W | Evicted line address |
| dec_valid | output | 1 | Decision issued this cycle |
| dec_action | output | 2 | Action code of the decision |

## Verification
A decision for a request accepted at edge k is sampled at the falling edge after edge k+2. For snoop-then-forward, the forward and its supply flag are sampled one falling edge later. The one-cycle hold after a collision is checked at the falling edge after k+3 and its released decision after k+4. Fill, evict and exclude updates take effect at the edge that samples them. A behavioural reference model applies them at that same edge and is compared with every output at each falling edge. Fills and evicts are kept apart from requests that are in flight for the same address.

// File: rtl/ring_snoop_ctl.sv
module ring_snoop_ctl #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 5,
  parameter int CNT_W  = 4,
  parameter int EXCL_N = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              ring_in_ready,
  output logic              ring_out_valid,
  output logic [ADDR_W-1:0] ring_out_addr,
  output logic              ring_out_supply,
  output logic              snp_valid,
  output logic [ADDR_W-1:0] snp_addr,
  input  logic              snp_hit,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  output logic              dec_valid,
  output logic [1:0]        dec_action
);
  localparam int NCNT = 1 << IDX_W;
  localparam int PTR_W = (EXCL_N > 1) ? $clog2(EXCL_N) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [1:0] ACT_STF = 2'd1, ACT_FTS = 2'd2, ACT_FO = 2'd3;

  function automatic logic [IDX_W-1:0] hash0(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0] ^ a[2*IDX_W-1:IDX_W];
  endfunction
  function automatic logic [IDX_W-1:0] hash1(input logic [ADDR_W-1:0] a);
    return {a[IDX_W-2:0], a[IDX_W-1]} ^ a[ADDR_W-1 -: IDX_W];
  endfunction

  logic              s1_v, s2_v, s3_v, s2_pred, s3_pred;
  logic [ADDR_W-1:0] s1_a, s2_a, s3_a;
  logic [1:0]        s3_act, nxt_act;
  logic              pend_v, pend_hit;
  logic [ADDR_W-1:0] pend_a;
  logic [PTR_W-1:0]  ptr;
  logic [NCNT-1:0]   nz;
  logic [EXCL_N-1:0] ex_m;

  wire [IDX_W-1:0] f0 = hash0(fill_addr),  f1 = hash1(fill_addr);
  wire [IDX_W-1:0] e0 = hash0(evict_addr), e1 = hash1(evict_addr);

  wire stall  = pend_v & s3_v & (s3_act != ACT_STF);
  wire issue  = s3_v & ~stall;
  wire snoop  = issue & (s3_act != ACT_FO);
  wire lrn    = snoop & s3_pred & ~snp_hit & ~(fill_valid && fill_addr == s3_a);
  wire bloom  = nz[hash0(s1_a)] & nz[hash1(s1_a)];
  wire pred1  = bloom & ~(|ex_m);

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    logic [CNT_W-1:0] c;
    wire [1:0] up = {1'b0, fill_valid && f0 == IDX_W'(i)} + {1'b0, fill_valid && f1 == IDX_W'(i)};
    wire [1:0] dn = {1'b0, evict_valid && e0 == IDX_W'(i)} + {1'b0, evict_valid && e1 == IDX_W'(i)};
    wire [CNT_W+1:0] nxt = {2'b00, c} + {{CNT_W{1'b0}}, up} - {{CNT_W{1'b0}}, dn};
    always_ff @(posedge clk)
      if (!rst_n) c <= '0;
      else if (c != CNT_MAX) c <= (nxt > {2'b00, CNT_MAX}) ? CNT_MAX : nxt[CNT_W-1:0];
    assign nz[i] = (c != '0);
  end

  for (genvar i = 0; i < EXCL_N; i++) begin : g_ex
    logic              v;
    logic [ADDR_W-1:0] a;
    always_ff @(posedge clk)
      if (!rst_n) begin
        v <= 1'b0;
        a <= '0;
      end else if (lrn && ptr == PTR_W'(i)) begin
        v <= 1'b1;
        a <= s3_a;
      end else if (fill_valid && v && a == fill_addr) v <= 1'b0;
    assign ex_m[i] = v && (a == s1_a);
  end

  always_ff @(posedge clk)
    if (!rst_n) ptr <= '0;
    else if (lrn) ptr <= (ptr == PTR_W'(EXCL_N-1)) ? '0 : ptr + 1'b1;

  always_comb
    case (mode)
      2'd0:    nxt_act = ACT_STF;
      2'd1:    nxt_act = ACT_FTS;
      2'd2:    nxt_act = s2_pred ? ACT_STF : ACT_FO;
      default: nxt_act = s2_pred ? ACT_FTS : ACT_FO;
    endcase

  always_ff @(posedge clk)
    if (!rst_n) begin
      {s1_v, s2_v, s3_v, s2_pred, s3_pred} <= '0;
      {s1_a, s2_a, s3_a} <= '0;
      s3_act <= ACT_FO;
    end else if (!stall) begin
      s1_v <= req_valid;  s1_a <= req_addr;
      s2_v <= s1_v;       s2_a <= s1_a;  s2_pred <= pred1;
      s3_v <= s2_v;       s3_a <= s2_a;  s3_pred <= s2_pred;  s3_act <= nxt_act;
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      pend_v <= 1'b0; pend_hit <= 1'b0; pend_a <= '0;
    end else begin
      pend_v <= issue && s3_act == ACT_STF;
      pend_a <= s3_a;
      pend_hit <= snp_hit;
    end

  assign ring_in_ready   = ~stall;
  assign dec_valid       = issue;
  assign dec_action      = s3_act;
  assign snp_valid       = snoop;
  assign snp_addr        = s3_a;
  assign ring_out_valid  = pend_v | (issue & (s3_act != ACT_STF));
  assign ring_out_addr   = pend_v ? pend_a : s3_a;
  assign ring_out_supply = pend_v & pend_hit;

  AST_LAZY_STF: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && mode == 2'd0) |-> dec_action == ACT_STF); // R2
  AST_EAGER_FTS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && mode == 2'd1) |-> (dec_action == ACT_FTS && ring_out_valid && snp_valid)); // R3
  AST_FO_ADAPTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_action == ACT_FO) |-> (mode[1] && !snp_valid && ring_out_valid)); // R4
  AST_STF_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && dec_action == ACT_STF) |=>
      (ring_out_valid && ring_out_addr == $past(snp_addr) && ring_out_supply == $past(snp_hit))); // R2
  AST_SUPPLY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    ring_out_supply |-> $past(snp_valid && snp_hit && dec_action == ACT_STF)); // R2
  AST_HOLD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_in_ready |=> ring_in_ready); // R8
endmodule

// File: tb/test_ring_snoop_ctl.sv
`timescale 1ns/1ps
module test_ring_snoop_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd2;
  logic req_valid = 1'b0, fill_valid = 1'b0, evict_valid = 1'b0;
  logic [15:0] req_addr = '0, fill_addr = '0, evict_addr = '0;
  logic ring_in_ready, ring_out_valid, ring_out_supply, snp_valid, snp_hit, dec_valid;
  logic [15:0] ring_out_addr, snp_addr;
  logic [1:0] dec_action;
  logic sup [0:1023];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;
  assign snp_hit = sup[snp_addr[9:0]];

  ring_snoop_ctl i_ring_snoop_ctl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .req_valid(req_valid), .req_addr(req_addr),
    .ring_in_ready(ring_in_ready), .ring_out_valid(ring_out_valid), .ring_out_addr(ring_out_addr),
    .ring_out_supply(ring_out_supply), .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_hit(snp_hit),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .evict_valid(evict_valid), .evict_addr(evict_addr),
    .dec_valid(dec_valid), .dec_action(dec_action));

  // reference model
  int cm [0:31];
  bit exv [0:3];
  int exa [0:3];
  int ptr;
  bit v1, v2, v3, p2, p3, pv, ph;
  int a1, a2, a3, act3, pa;

  function automatic int fh0(int a); return (a & 31) ^ ((a >> 5) & 31); endfunction
  function automatic int fh1(int a); return (((a << 1) & 30) | ((a >> 4) & 1)) ^ ((a >> 11) & 31); endfunction
  function automatic int pick(int m, bit p);
    if (m == 0) return 1;
    if (m == 1) return 2;
    if (!p) return 3;
    return (m == 2) ? 1 : 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (cm[k]) cm[k] = 0;
      foreach (exv[k]) begin exv[k] = 0; exa[k] = 0; end
      ptr = 0; v1 = 0; v2 = 0; v3 = 0; p2 = 0; p3 = 0; pv = 0; ph = 0;
      a1 = 0; a2 = 0; a3 = 0; act3 = 3; pa = 0;
    end else begin
      bit st, iss, hit, lrn, bl, ex, npv;
      int ins;
      st  = pv && v3 && act3 != 1;
      iss = v3 && !st;
      hit = sup[a3[9:0]];
      lrn = iss && act3 != 3 && p3 && !hit && !(fill_valid && int'(fill_addr) == a3);
      bl  = cm[fh0(a1)] > 0 && cm[fh1(a1)] > 0;
      ex  = 0;
      foreach (exv[k]) if (exv[k] && exa[k] == a1) ex = 1;
      ins = -1;
      if (lrn) begin exv[ptr] = 1; exa[ptr] = a3; ins = ptr; ptr = (ptr + 1) % 4; end
      if (fill_valid) foreach (exv[k]) if (k != ins && exv[k] && exa[k] == int'(fill_addr)) exv[k] = 0;
      if (fill_valid) begin cm[fh0(fill_addr)]++; cm[fh1(fill_addr)]++; end
      if (evict_valid) begin cm[fh0(evict_addr)]--; cm[fh1(evict_addr)]--; end
      npv = iss && act3 == 1;
      if (npv) begin pa = a3; ph = hit; end
      pv = npv;
      if (!st) begin
        v3 = v2; a3 = a2; p3 = p2; act3 = pick(mode, p2);
        v2 = v1; a2 = a1; p2 = bl && !ex;
        v1 = req_valid; a1 = req_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit st, iss, rov;
    st  = pv && v3 && act3 != 1;
    iss = v3 && !st;
    rov = pv || (iss && act3 != 1);
    chk(ring_in_ready == !st, "R8 model ring_in_ready", ring_in_ready, !st);
    chk(dec_valid == iss && (!iss || dec_action == act3), "R1 model decision",
        {dec_valid, dec_action}, {iss, act3[1:0]});
    chk(snp_valid == (iss && act3 != 3) && (!snp_valid || snp_addr == a3), "R4 model snoop",
        {snp_valid, snp_addr}, {iss && act3 != 3, a3[15:0]});
    chk(ring_out_valid == rov && (!rov || (ring_out_addr == (pv ? pa : a3) && ring_out_supply == (pv && ph))),
        "R2 model forward", {ring_out_valid, ring_out_supply, ring_out_addr},
        {rov, pv && ph, pv ? pa[15:0] : a3[15:0]});
  end

  task automatic fill(input int a);
    @(negedge clk); fill_valid = 1; fill_addr = a[15:0]; sup[a[9:0]] = 1;
    @(negedge clk); fill_valid = 0;
  endtask
  task automatic evict(input int a);
    @(negedge clk); evict_valid = 1; evict_addr = a[15:0]; sup[a[9:0]] = 0;
    @(negedge clk); evict_valid = 0;
  endtask

  task automatic req1(input int a, input int exp, input string tag);
    repeat (2) @(negedge clk);
    req_valid = 1; req_addr = a[15:0];
    @(negedge clk); req_valid = 0;
    @(negedge clk); @(negedge clk);
    chk(dec_valid && dec_action == exp, {tag, " decision"}, {dec_valid, dec_action}, {1'b1, exp[1:0]});
    if (exp == 1) begin
      chk(snp_valid && !ring_out_valid, {tag, " snoop first"}, {snp_valid, ring_out_valid}, 2'b10);
      @(negedge clk);
      chk(ring_out_valid && ring_out_addr == a[15:0] && ring_out_supply == sup[a[9:0]],
          {tag, " late forward"}, {ring_out_valid, ring_out_supply}, {1'b1, sup[a[9:0]]});
    end else if (exp == 2)
      chk(snp_valid && ring_out_valid && !ring_out_supply, {tag, " forward and snoop"},
          {snp_valid, ring_out_valid, ring_out_supply}, 3'b110);
    else
      chk(!snp_valid && ring_out_valid, {tag, " forward only"}, {snp_valid, ring_out_valid}, 2'b01);
    repeat (2) @(negedge clk);
  endtask

  task automatic burst(input int m, input int n);
    mode = m[1:0];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!(req_valid && !ring_in_ready)) begin
        int r;
        r = $urandom_range(0, 5);
        req_valid = ($urandom_range(0, 3) != 0);
        case (r)
          0, 1: req_addr = 16'($urandom_range(0, 31));
          2:    req_addr = 16'($urandom_range(16'h100, 16'h104));
          3:    req_addr = 16'h0A5;
          default: req_addr = 16'($urandom_range(0, 1023));
        endcase
      end
    end
    @(negedge clk);
    while (!ring_in_ready) @(negedge clk);
    req_valid = 0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    foreach (sup[k]) sup[k] = 0;
    repeat (3) @(negedge clk);
    chk(ring_in_ready && !dec_valid && !snp_valid && !ring_out_valid, "R9 reset outputs",
        {ring_in_ready, dec_valid, snp_valid, ring_out_valid}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(ring_in_ready && !ring_out_valid, "R9 after reset", {ring_in_ready, ring_out_valid}, 2'b10);

    mode = 2; req1(16'h0A5, 3, "R9 empty filter");
    fill(16'h0A5); fill(16'h006);
    req1(16'h0A5, 1, "R4 conservative supplier");
    mode = 3; req1(16'h0A5, 2, "R4 aggressive supplier");
    mode = 0; req1(16'h3C0, 1, "R2 lazy");
    mode = 1; req1(16'h3C0, 2, "R3 eager");
    mode = 2; req1(16'h065, 1, "R6 false positive snoop");
    req1(16'h065, 3, "R6 excluded");
    fill(16'h065); req1(16'h065, 1, "R5 fill clears exclusion");
    evict(16'h065); evict(16'h006);
    req1(16'h006, 3, "R7 evicted");

    for (int a = 0; a < 32; a++) fill(a);
    for (int e = 16'h100; e <= 16'h104; e++) req1(e, 1, "R6 learn");
    req1(16'h101, 3, "R6 entry kept");
    req1(16'h100, 1, "R6 round robin replaced");

    @(negedge clk); req_valid = 1; req_addr = 16'h003;
    @(negedge clk); req_addr = 16'h102;
    @(negedge clk); req_valid = 0;
    @(negedge clk);
    chk(dec_valid && dec_action == 1, "R8 first decision", dec_action, 1);
    @(negedge clk);
    chk(!ring_in_ready && !dec_valid && ring_out_valid && ring_out_supply && ring_out_addr == 16'h003,
        "R8 hold", {ring_in_ready, dec_valid, ring_out_valid, ring_out_supply}, 4'b0011);
    @(negedge clk);
    chk(ring_in_ready && dec_valid && dec_action == 3 && ring_out_addr == 16'h102,
        "R8 released", {ring_in_ready, dec_valid, dec_action}, 4'b1111);
    repeat (4) @(negedge clk);

    burst(2, 300); burst(3, 300); burst(0, 300); burst(1, 200);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule